// File: doc/BRIEF.md
# Normalizing Branch Metric Unit

This block forms the four branch metrics of one trellis step for a rate 1/2 recursive systematic code decoded with the max-log a-posteriori method. Each cycle it takes a received systematic soft value, a received parity soft value and the a-priori soft value returned by the partner constituent decoder. It adds and subtracts them for every combination of the two hypothesised code bits. With the noise variance fixed at 2, the metric needs no multiplier or divider, and the only scaling is one arithmetic shift.

The metrics are then rebased in the same cycle. One set has the largest metric subtracted from every lane, so each value is zero or negative. The other set has the smallest metric subtracted, so each value is zero or positive. A state metric recursion fed from either set stays bounded without its own renormalization stage. One new input set is accepted every cycle. Both result sets appear one register stage later, together with a valid flag.

Top module: `branch_metric_norm`

## Requirements
- R1: Lane i (i = 0..3) carries hypothesis u = +1 when bit 1 of i is set (else -1) and p = +1 when bit 0 of i is set (else -1). Its raw metric is floor((u*(sys + apr) + p*par) / 2^SCALE_SHIFT), with SCALE_SHIFT = 1 by default and all inputs signed 8-bit two's complement.
- R2: Each lane of the max-referenced output equals its metric minus the largest of the four metrics, so every lane is zero or negative and at least one lane is zero when no saturation occurs.
- R3: Each lane of the min-referenced output equals its metric minus the smallest of the four metrics, so every lane is zero or positive and at least one lane is zero.
- R4: Outputs are signed OUT_W-bit values (default 8). A max-referenced lane below -2^(OUT_W-1) is clamped to -2^(OUT_W-1), and a min-referenced lane above 2^(OUT_W-1)-1 is clamped to 2^(OUT_W-1)-1.
- R5: An input set presented with inValid high at a rising edge gives its results and outValid high right after that edge. Back-to-back inputs are accepted every cycle, and outValid always equals inValid one cycle earlier.
- R6: At an edge with inValid low, both output buses keep their previous values and outValid goes low.
- R7: While rst_n is low, outValid and every output lane are zero.
- R8: On both buses, lane i occupies bits [i*OUT_W +: OUT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input set valid |
| sysSoft | input | 8 | Received systematic soft value, signed |
| parSoft | input | 8 | Received parity soft value, signed |
| aprSoft | input | 8 | A-priori soft value from the partner decoder, signed |
| outValid | output | 1 | Result sets valid |
| maxRefBus | output | 4*OUT_W | Metrics minus largest metric, four signed lanes |
| minRefBus | output | 4*OUT_W | Metrics minus smallest metric, four signed lanes |

## Verification
A wrong extremum or a wrong lane hypothesis shows on the very next cycle. The zero lane lands in the wrong position, or a lane of the wrong sign appears on one of the buses. The bench sweeps a dense grid of the three soft inputs plus every extreme combination, so the saturation thresholds are hit on both buses. A streaming burst and idle gaps show that a faulty capture strobe or valid delay breaks the one-cycle alignment between a result and its flag.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  localparam int LANES = 4;

  typedef struct packed {
    logic load;
  } bmuStrobe_t;

endpackage

// File: rtl/bmu_ctrl.sv
module bmu_ctrl
  import bmu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output bmuStrobe_t strobe,
  output logic       outValid
);

  always_comb begin
    strobe.load = inValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

endmodule

// File: rtl/bmu_metric_gen.sv
module bmu_metric_gen #(
  parameter int IN_W        = 8,
  parameter int SCALE_SHIFT = 1,
  localparam int SUM_W      = IN_W + 2
) (
  input  logic signed [IN_W-1:0]  sysSoft,
  input  logic signed [IN_W-1:0]  parSoft,
  input  logic signed [IN_W-1:0]  aprSoft,
  output logic signed [SUM_W-1:0] metric [4]
);

  logic signed [SUM_W-1:0] sysSum;
  logic signed [SUM_W-1:0] parExt;

  assign sysSum = {{2{sysSoft[IN_W-1]}}, sysSoft} + {{2{aprSoft[IN_W-1]}}, aprSoft};
  assign parExt = {{2{parSoft[IN_W-1]}}, parSoft};

  for (genvar i = 0; i < 4; i++) begin : g_lane
    logic signed [SUM_W-1:0] uTerm;
    logic signed [SUM_W-1:0] pTerm;
    logic signed [SUM_W-1:0] rawSum;
    assign uTerm  = (i / 2 == 1) ? sysSum : -sysSum;
    assign pTerm  = (i % 2 == 1) ? parExt : -parExt;
    assign rawSum = uTerm + pTerm;
    assign metric[i] = rawSum >>> SCALE_SHIFT;
  end

endmodule

// File: rtl/bmu_datapath.sv
module bmu_datapath
  import bmu_pkg::*;
#(
  parameter int IN_W        = 8,
  parameter int OUT_W       = 8,
  parameter int SCALE_SHIFT = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bmuStrobe_t               strobe,
  input  logic signed [IN_W-1:0]   sysSoft,
  input  logic signed [IN_W-1:0]   parSoft,
  input  logic signed [IN_W-1:0]   aprSoft,
  output logic [LANES*OUT_W-1:0]   maxRefBus,
  output logic [LANES*OUT_W-1:0]   minRefBus
);

  localparam int SUM_W  = IN_W + 2;
  localparam int DIFF_W = SUM_W + 1;
  localparam logic signed [DIFF_W-1:0] SAT_HI = DIFF_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [DIFF_W-1:0] SAT_LO = -SAT_HI - DIFF_W'(1);

  logic signed [SUM_W-1:0] metric [4];
  logic signed [SUM_W-1:0] bigVal;
  logic signed [SUM_W-1:0] smallVal;

  bmu_metric_gen #(
    .IN_W(IN_W),
    .SCALE_SHIFT(SCALE_SHIFT)
  ) metricGen (
    .sysSoft(sysSoft),
    .parSoft(parSoft),
    .aprSoft(aprSoft),
    .metric(metric)
  );

  always_comb begin
    bigVal   = metric[0];
    smallVal = metric[0];
    for (int i = 1; i < LANES; i++) begin
      if (metric[i] > bigVal)   bigVal   = metric[i];
      if (metric[i] < smallVal) smallVal = metric[i];
    end
  end

  function automatic logic [OUT_W-1:0] satVal(input logic signed [DIFF_W-1:0] v);
    if (v > SAT_HI)      satVal = SAT_HI[OUT_W-1:0];
    else if (v < SAT_LO) satVal = SAT_LO[OUT_W-1:0];
    else                 satVal = v[OUT_W-1:0];
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_norm
    logic signed [DIFF_W-1:0] toMax;
    logic signed [DIFF_W-1:0] toMin;
    logic [OUT_W-1:0] maxReg;
    logic [OUT_W-1:0] minReg;

    assign toMax = {metric[i][SUM_W-1], metric[i]} - {bigVal[SUM_W-1], bigVal};
    assign toMin = {metric[i][SUM_W-1], metric[i]} - {smallVal[SUM_W-1], smallVal};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        maxReg <= '0;
        minReg <= '0;
      end else if (strobe.load) begin
        maxReg <= satVal(toMax);
        minReg <= satVal(toMin);
      end
    end

    assign maxRefBus[i*OUT_W +: OUT_W] = maxReg;
    assign minRefBus[i*OUT_W +: OUT_W] = minReg;
  end

endmodule

// File: rtl/branch_metric_norm.sv
module branch_metric_norm
  import bmu_pkg::*;
#(
  parameter int IN_W        = 8,
  parameter int OUT_W       = 8,
  parameter int SCALE_SHIFT = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inValid,
  input  logic [IN_W-1:0]        sysSoft,
  input  logic [IN_W-1:0]        parSoft,
  input  logic [IN_W-1:0]        aprSoft,
  output logic                   outValid,
  output logic [4*OUT_W-1:0]     maxRefBus,
  output logic [4*OUT_W-1:0]     minRefBus
);

  bmuStrobe_t strobe;

  bmu_ctrl ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .inValid(inValid),
    .strobe(strobe),
    .outValid(outValid)
  );

  bmu_datapath #(
    .IN_W(IN_W),
    .OUT_W(OUT_W),
    .SCALE_SHIFT(SCALE_SHIFT)
  ) datapath (
    .clk(clk),
    .rst_n(rst_n),
    .strobe(strobe),
    .sysSoft($signed(sysSoft)),
    .parSoft($signed(parSoft)),
    .aprSoft($signed(aprSoft)),
    .maxRefBus(maxRefBus),
    .minRefBus(minRefBus)
  );

endmodule

// File: rtl/branch_metric_norm_chk.sv
module branch_metric_norm_chk #(
  parameter int OUT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic               outValid,
  input logic [4*OUT_W-1:0] maxRefBus,
  input logic [4*OUT_W-1:0] minRefBus
);

  logic maxAllNonPos, minAllNonNeg, minHasZero;

  always_comb begin
    maxAllNonPos = 1'b1;
    minAllNonNeg = 1'b1;
    minHasZero   = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if ((maxRefBus[i*OUT_W +: OUT_W] != '0) && !maxRefBus[i*OUT_W + OUT_W - 1])
        maxAllNonPos = 1'b0;
      if (minRefBus[i*OUT_W + OUT_W - 1]) minAllNonNeg = 1'b0;
      if (minRefBus[i*OUT_W +: OUT_W] == '0) minHasZero = 1'b1;
    end
  end

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R6
  idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R6
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(maxRefBus) && $stable(minRefBus)));

  // R2
  max_nonpos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> maxAllNonPos);

  // R3
  min_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (minAllNonNeg && minHasZero));

endmodule

bind branch_metric_norm branch_metric_norm_chk #(.OUT_W(OUT_W)) normChk (
  .clk(clk),
  .rst_n(rst_n),
  .inValid(inValid),
  .outValid(outValid),
  .maxRefBus(maxRefBus),
  .minRefBus(minRefBus)
);

// File: tb/branch_metric_norm_test.sv
`timescale 1ns/1ps
module branch_metric_norm_test;

  localparam int OW = 8;
  localparam int SH = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] sysSoft = '0, parSoft = '0, aprSoft = '0;
  logic outValid;
  logic [4*OW-1:0] maxRefBus, minRefBus;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  branch_metric_norm #(.IN_W(8), .OUT_W(OW), .SCALE_SHIFT(SH)) uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .sysSoft(sysSoft), .parSoft(parSoft), .aprSoft(aprSoft),
    .outValid(outValid), .maxRefBus(maxRefBus), .minRefBus(minRefBus)
  );

  function automatic int refMetric(int ys, int yp, int la, int idx);
    int u, p, raw;
    u = (idx / 2 == 1) ? 1 : -1;
    p = (idx % 2 == 1) ? 1 : -1;
    raw = u * (ys + la) + p * yp;
    return raw >>> SH;
  endfunction

  function automatic int clampTo(int v);
    int hi, lo;
    hi = (1 << (OW - 1)) - 1;
    lo = -(1 << (OW - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic logic [8*OW-1:0] expectBuses(int ys, int yp, int la);
    int g[4];
    int mx, mn;
    logic [4*OW-1:0] eMax, eMin;
    for (int i = 0; i < 4; i++) g[i] = refMetric(ys, yp, la, i);
    mx = g[0]; mn = g[0];
    for (int i = 1; i < 4; i++) begin
      if (g[i] > mx) mx = g[i];
      if (g[i] < mn) mn = g[i];
    end
    for (int i = 0; i < 4; i++) begin
      eMax[i*OW +: OW] = OW'(clampTo(g[i] - mx));
      eMin[i*OW +: OW] = OW'(clampTo(g[i] - mn));
    end
    return {eMax, eMin};
  endfunction

  task automatic checkEq(string req, logic [4*OW-1:0] act, logic [4*OW-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic driveSet(int ys, int yp, int la, logic v);
    sysSoft = 8'(ys);
    parSoft = 8'(yp);
    aprSoft = 8'(la);
    inValid = v;
  endtask

  task automatic applyOne(string req, int ys, int yp, int la);
    logic [8*OW-1:0] e;
    @(negedge clk);
    driveSet(ys, yp, la, 1'b1);
    e = expectBuses(ys, yp, la);
    @(negedge clk);
    checkEq({req, " maxRef"}, maxRefBus, e[8*OW-1:4*OW]);
    checkEq({req, " minRef"}, minRefBus, e[4*OW-1:0]);
    checkBit({req, " R5 outValid"}, outValid, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL R5 watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [8*OW-1:0] prevExp;
    logic [4*OW-1:0] heldMax, heldMin;
    int ext[3];

    // R7: reset state
    repeat (3) @(negedge clk);
    checkBit("R7 outValid", outValid, 1'b0);
    checkEq("R7 maxRef", maxRefBus, '0);
    checkEq("R7 minRef", minRefBus, '0);
    rst_n = 1'b1;

    // R1 R8: single hypothesis visibility with one nonzero input
    applyOne("R1 R8 sys only", 40, 0, 0);
    applyOne("R1 R8 par only", 0, 30, 0);
    applyOne("R1 R8 apr only", 0, 0, -50);
    applyOne("R1 floor odd", 3, -1, 0);

    // R4: extremes on every input
    ext[0] = -128; ext[1] = 0; ext[2] = 127;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          applyOne("R4 R2 R3 extreme", ext[a], ext[b], ext[c]);

    // R1 R2 R3 R4: near-exhaustive sweep
    for (int ys = -128; ys < 128; ys += 7)
      for (int la = -128; la < 128; la += 13)
        for (int yp = -128; yp < 128; yp += 9)
          applyOne("R1 R2 R3 sweep", ys, yp, la);

    // R5: back-to-back burst, one result per cycle
    for (int k = 0; k <= 64; k++) begin
      @(negedge clk);
      if (k > 0) begin
        checkEq("R5 burst maxRef", maxRefBus, prevExp[8*OW-1:4*OW]);
        checkEq("R5 burst minRef", minRefBus, prevExp[4*OW-1:0]);
        checkBit("R5 burst outValid", outValid, 1'b1);
      end
      if (k < 64) begin
        driveSet((k * 37) % 256 - 128, (k * 91) % 256 - 128, (k * 53) % 256 - 128, 1'b1);
        prevExp = expectBuses((k * 37) % 256 - 128, (k * 91) % 256 - 128, (k * 53) % 256 - 128);
      end
    end

    // R6: idle inputs change nothing
    applyOne("R6 setup", 17, -45, 60);
    heldMax = maxRefBus;
    heldMin = minRefBus;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      driveSet(-100 + k * 50, 90 - k * 40, 127 - k * 80, 1'b0);
      @(negedge clk);
      checkBit("R6 outValid low", outValid, 1'b0);
      checkEq("R6 maxRef held", maxRefBus, heldMax);
      checkEq("R6 minRef held", minRefBus, heldMin);
    end

    // R5: result after idle gap
    applyOne("R5 after idle", -7, 100, 22);

    // R7: reset mid-stream clears outputs
    @(negedge clk);
    inValid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    checkBit("R7 reset outValid", outValid, 1'b0);
    checkEq("R7 reset maxRef", maxRefBus, '0);
    checkEq("R7 reset minRef", minRefBus, '0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule